// File: doc/BRIEF.md
# 3x3 Neighbourhood Window with Line Buffers

This block holds the 3x3 pixel neighbourhood that a streaming 2-D filter, such as an edge detector, works on. Each call brings one new 32-bit sample and a column position. The block slides the window one column to the left. It then fills the freed right-hand column from two line buffers and the new sample, and rotates the two line buffers at that column. The line buffers hold the two rows above the current one.

A call starts with a one-cycle `start`. The block samples `sample_in` and `pos_in` in that cycle and ignores them for the rest of the call. The window store and each line buffer accept at most two accesses per cycle, and their reads return data one cycle after the address. The call therefore runs as a fixed sequence of reads and writes. `done` rises seven cycles after the start cycle. A new call can be accepted eight cycles after the previous one. A combinational read port lets the filter datapath, or a bench, look at any of the nine window words.

Top module: `nbhd_window`

## Requirements
- R1: After a synchronous active-high reset, all nine window words read as zero, every line-buffer entry is zero, and `done` is low.
- R2: After a call, window words 0, 1, 3, 4, 6 and 7 hold the values that words 1, 2, 4, 5, 7 and 8 held before the call. Words are numbered row-major, with 2, 5 and 8 as the newest column.
- R3: After a call at an in-range position p, word 2 holds the older line buffer's entry p from before the call, and word 5 holds the newer line buffer's entry p from before the call.
- R4: After a call, word 8 holds the sample given with `start`.
- R5: A call at in-range position p copies the newer buffer's previous entry p into the older buffer's entry p, and then writes the sample into the newer buffer's entry p. The older buffer is written first.
- R6: `done` is high for exactly one cycle, seven cycles after the cycle in which `start` was accepted. The updated window is visible on the read port from the following cycle.
- R7: `start` is accepted only when no call is in progress. It is ignored from the cycle after acceptance through the `done` cycle. If `start` is held high, a second call is accepted eight cycles after the first.
- R8: `sample_in` and `pos_in` are captured in the accept cycle. Changes to them during the call have no effect on its result.
- R9: A position of 20 or more leaves both line buffers unchanged. The window still shifts, with zero entering words 2 and 5 and the sample entering word 8.
- R10: `rd_word` shows window word `rd_sel` combinationally for `rd_sel` 0 to 8, and zero for `rd_sel` 9 to 15.
- R11: Window and line-buffer writes occur only during a call. When both window ports write in the same cycle, they target different words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request one window update |
| sample_in | input | 32 | New sample for the bottom-right word |
| pos_in | input | 6 | Column position within the line |
| done | output | 1 | One-cycle pulse when the final writes of a call are issued |
| rd_sel | input | 4 | Window word select for the read port |
| rd_word | output | 32 | Selected window word |

## Verification
On every cycle, the assertions check the call timing: `done` follows an accepted start by exactly seven cycles, lasts a single cycle, and never appears without an accepted start. They also check that storage writes happen only inside a call, that the two window ports never write the same word, and that the newer buffer is written only in the cycle after the older one. The data movement needs the bench's scenarios, which compare the window against a software model after every call. That covers the shift, the right-column fill, and the buffer rotation over three full rows, where values from two rows earlier reach word 2. The scenarios also cover inputs that change during a call, out-of-range positions, a held `start`, and read selects past the last word.

// File: rtl/nbhd_pkg.sv
package nbhd_pkg;
   localparam int unsigned NWORDS  = 9;
   localparam int unsigned WSEL_W  = 4;
   localparam int unsigned NSTAGE  = 6;
   localparam int unsigned LATENCY = 7;

   // sequencing steps; step 1 only exists combinationally (idle + start)
   typedef enum logic [3:0] {
      ST_IDLE   = 4'd0,
      ST_RD_TOP = 4'd1,
      ST_RD_MID = 4'd2,
      ST_RD_BOT = 4'd3,
      ST_WR_TOP = 4'd4,
      ST_WR_MID = 4'd5,
      ST_WR_BOT = 4'd6,
      ST_FILL   = 4'd7,
      ST_TAIL   = 4'd8
   } step_t;
endpackage

// File: rtl/nbhd_seq.sv
module nbhd_seq
   import nbhd_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  start,
   output step_t cur,
   output logic  accept,
   output logic  busy,
   output logic  done
);
   step_t step;

   always_ff @(posedge clk) begin
      if (rst) begin
         step <= ST_IDLE;
      end else if (step == ST_IDLE) begin
         if (start) step <= ST_RD_MID;
      end else if (step == ST_TAIL) begin
         step <= ST_IDLE;
      end else begin
         step <= step_t'(step + 4'd1);
      end
   end

   assign accept = (step == ST_IDLE) && start;
   assign cur    = accept ? ST_RD_TOP : step;
   assign busy   = (step != ST_IDLE);
   assign done   = (step == ST_TAIL);
endmodule

// File: rtl/nbhd_wregs.sv
module nbhd_wregs #(
   parameter int unsigned DW    = 32,
   parameter int unsigned N     = 9,
   parameter int unsigned SEL_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] a_addr,
   input  logic             a_we,
   input  logic [DW-1:0]    a_wd,
   output logic [DW-1:0]    a_q,
   input  logic [SEL_W-1:0] b_addr,
   input  logic             b_we,
   input  logic [DW-1:0]    b_wd,
   output logic [DW-1:0]    b_q,
   input  logic [SEL_W-1:0] pk_sel,
   output logic [DW-1:0]    pk_data
);
   localparam logic [SEL_W-1:0] NLIM = SEL_W'(N);

   logic [DW-1:0] mem [N];

   generate
      if (N >= (1 << SEL_W)) begin : g_bad_sel
         $error("nbhd_wregs: SEL_W too narrow for N");
      end
      for (genvar i = 0; i < N; i++) begin : g_word
         always_ff @(posedge clk) begin
            if (rst)                               mem[i] <= '0;
            else if (a_we && a_addr == SEL_W'(i))  mem[i] <= a_wd;
            else if (b_we && b_addr == SEL_W'(i))  mem[i] <= b_wd;
         end
      end
   endgenerate

   // synchronous reads, one cycle of latency, read-before-write
   always_ff @(posedge clk) begin
      if (rst) begin
         a_q <= '0;
         b_q <= '0;
      end else begin
         a_q <= (a_addr < NLIM) ? mem[a_addr] : '0;
         b_q <= (b_addr < NLIM) ? mem[b_addr] : '0;
      end
   end

   assign pk_data = (pk_sel < NLIM) ? mem[pk_sel] : '0;
endmodule

// File: rtl/nbhd_lbuf.sv
module nbhd_lbuf #(
   parameter int unsigned DW    = 32,
   parameter int unsigned DEPTH = 20,
   parameter int unsigned IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] idx,
   input  logic             rd,
   input  logic             we,
   input  logic [DW-1:0]    wd,
   output logic [DW-1:0]    q
);
   localparam int unsigned      ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [IDX_W-1:0] DLIM   = IDX_W'(DEPTH);

   logic [DW-1:0]     mem [DEPTH];
   logic              inb;
   logic [ADDR_W-1:0] a;

   assign inb = (idx < DLIM);
   assign a   = idx[ADDR_W-1:0];

   generate
      if (DEPTH >= (1 << IDX_W) || ADDR_W > IDX_W) begin : g_bad_depth
         $error("nbhd_lbuf: DEPTH must be below 2**IDX_W");
      end
      for (genvar i = 0; i < DEPTH; i++) begin : g_ent
         always_ff @(posedge clk) begin
            if (rst)                                mem[i] <= '0;
            else if (we && inb && a == ADDR_W'(i))  mem[i] <= wd;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (rd) q <= inb ? mem[a] : '0;
   end
endmodule

// File: rtl/nbhd_window.sv
module nbhd_window
   import nbhd_pkg::*;
#(
   parameter int unsigned DW       = 32,
   parameter int unsigned LINE_LEN = 20,
   parameter int unsigned POS_W    = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [DW-1:0]     sample_in,
   input  logic [POS_W-1:0]  pos_in,
   output logic              done,
   input  logic [WSEL_W-1:0] rd_sel,
   output logic [DW-1:0]     rd_word
);
   generate
      if (DW < 1 || LINE_LEN < 2 || LINE_LEN >= (1 << POS_W)) begin : g_bad_cfg
         $error("nbhd_window: illegal DW/LINE_LEN/POS_W combination");
      end
   endgenerate

   step_t             cur;
   logic              accept_w, busy_w;
   logic [POS_W-1:0]  pos_q;
   logic [DW-1:0]     samp_q;
   logic [DW-1:0]     stg [NSTAGE];

   logic [WSEL_W-1:0] a_addr, b_addr;
   logic              a_we, b_we;
   logic [DW-1:0]     a_wd, b_wd, a_q, b_q;
   logic              lb_rd, lbo_we, lbn_we;
   logic [DW-1:0]     lbo_wd, lbn_wd, lbo_q, lbn_q;

   nbhd_seq seq_i (
      .clk(clk), .rst(rst), .start(start),
      .cur(cur), .accept(accept_w), .busy(busy_w), .done(done)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pos_q  <= '0;
         samp_q <= '0;
      end else if (accept_w) begin
         pos_q  <= pos_in;
         samp_q <= sample_in;
      end
   end

   // staging for the six shifted words, captured as reads return
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < NSTAGE; k++) stg[k] <= '0;
      end else begin
         case (cur)
            ST_RD_MID: begin stg[0] <= a_q; stg[1] <= b_q; end
            ST_RD_BOT: begin stg[2] <= a_q; stg[3] <= b_q; end
            ST_WR_TOP: begin stg[4] <= a_q; stg[5] <= b_q; end
            default: ;
         endcase
      end
   end

   always_comb begin
      a_addr = '0; a_we = 1'b0; a_wd = '0;
      b_addr = '0; b_we = 1'b0; b_wd = '0;
      lb_rd  = 1'b0;
      lbo_we = 1'b0; lbo_wd = '0;
      lbn_we = 1'b0; lbn_wd = '0;
      case (cur)
         ST_RD_TOP: begin a_addr = WSEL_W'(1); b_addr = WSEL_W'(2); end
         ST_RD_MID: begin a_addr = WSEL_W'(4); b_addr = WSEL_W'(5); end
         ST_RD_BOT: begin a_addr = WSEL_W'(7); b_addr = WSEL_W'(8); end
         ST_WR_TOP: begin
            a_addr = WSEL_W'(0); a_we = 1'b1; a_wd = stg[0];
            b_addr = WSEL_W'(1); b_we = 1'b1; b_wd = stg[1];
         end
         ST_WR_MID: begin
            a_addr = WSEL_W'(3); a_we = 1'b1; a_wd = stg[2];
            b_addr = WSEL_W'(4); b_we = 1'b1; b_wd = stg[3];
         end
         ST_WR_BOT: begin
            a_addr = WSEL_W'(6); a_we = 1'b1; a_wd = stg[4];
            b_addr = WSEL_W'(7); b_we = 1'b1; b_wd = stg[5];
            lb_rd  = 1'b1;
         end
         ST_FILL: begin
            a_addr = WSEL_W'(2); a_we = 1'b1; a_wd = lbo_q;
            b_addr = WSEL_W'(5); b_we = 1'b1; b_wd = lbn_q;
            lbo_we = 1'b1;       lbo_wd = lbn_q;
         end
         ST_TAIL: begin
            a_addr = WSEL_W'(8); a_we = 1'b1; a_wd = samp_q;
            lbn_we = 1'b1;       lbn_wd = samp_q;
         end
         default: ;
      endcase
   end

   nbhd_wregs #(.DW(DW), .N(NWORDS), .SEL_W(WSEL_W)) win_i (
      .clk(clk), .rst(rst),
      .a_addr(a_addr), .a_we(a_we), .a_wd(a_wd), .a_q(a_q),
      .b_addr(b_addr), .b_we(b_we), .b_wd(b_wd), .b_q(b_q),
      .pk_sel(rd_sel), .pk_data(rd_word)
   );

   nbhd_lbuf #(.DW(DW), .DEPTH(LINE_LEN), .IDX_W(POS_W)) lb_old_i (
      .clk(clk), .rst(rst), .idx(pos_q), .rd(lb_rd),
      .we(lbo_we), .wd(lbo_wd), .q(lbo_q)
   );

   nbhd_lbuf #(.DW(DW), .DEPTH(LINE_LEN), .IDX_W(POS_W)) lb_new_i (
      .clk(clk), .rst(rst), .idx(pos_q), .rd(lb_rd),
      .we(lbn_we), .wd(lbn_wd), .q(lbn_q)
   );
endmodule

// File: rtl/nbhd_window_chk.sv
module nbhd_window_chk (
   input logic       clk,
   input logic       rst,
   input logic       accept,
   input logic       busy,
   input logic       done,
   input logic       a_we,
   input logic       b_we,
   input logic [3:0] a_addr,
   input logic [3:0] b_addr,
   input logic       lbo_we,
   input logic       lbn_we
);
   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
      accept |-> ##7 done);                                       // R6
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);                                            // R6
   AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
      done |-> $past(accept, 7));                                 // R7
   AST_NO_DOUBLE_ACCEPT: assert property (@(posedge clk) disable iff (rst)
      accept |=> !accept);                                        // R7
   AST_PORTS_DISTINCT: assert property (@(posedge clk) disable iff (rst)
      (a_we && b_we) |-> (a_addr != b_addr));                     // R11
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      !busy |-> !(a_we || b_we || lbo_we || lbn_we));             // R11
   AST_ROTATE_ORDER: assert property (@(posedge clk) disable iff (rst)
      lbn_we |-> $past(lbo_we));                                  // R5
endmodule

bind nbhd_window nbhd_window_chk chk_i (
   .clk(clk), .rst(rst), .accept(accept_w), .busy(busy_w), .done(done),
   .a_we(a_we), .b_we(b_we), .a_addr(a_addr), .b_addr(b_addr),
   .lbo_we(lbo_we), .lbn_we(lbn_we)
);

// File: tb/nbhd_window_tb_top.sv
`timescale 1ns/1ps
module nbhd_window_tb_top;
   localparam int LEN = 20;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [31:0] sample_in = '0;
   logic [5:0]  pos_in = '0;
   logic        done;
   logic [3:0]  rd_sel = '0;
   logic [31:0] rd_word;

   int checks = 0;
   int fails  = 0;

   logic [31:0] m_win [9];
   logic [31:0] m_old [LEN];
   logic [31:0] m_new [LEN];

   always #2 clk = ~clk;

   nbhd_window dut_i (
      .clk(clk), .rst(rst), .start(start), .sample_in(sample_in),
      .pos_in(pos_in), .done(done), .rd_sel(rd_sel), .rd_word(rd_word)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // reference: R2 shift, R3 fill, R4 sample, R5 rotation, R9 out of range
   task automatic model_upd(input logic [31:0] d, input int p);
      logic [31:0] o, n;
      o = '0; n = '0;
      if (p < LEN) begin
         o = m_old[p];
         n = m_new[p];
         m_old[p] = n;
         m_new[p] = d;
      end
      m_win[0] = m_win[1]; m_win[1] = m_win[2]; m_win[2] = o;
      m_win[3] = m_win[4]; m_win[4] = m_win[5]; m_win[5] = n;
      m_win[6] = m_win[7]; m_win[7] = m_win[8]; m_win[8] = d;
   endtask

   task automatic check_window(input string req);
      for (int k = 0; k < 9; k++) begin
         @(negedge clk);
         rd_sel = 4'(k);
         #0.5;
         chk($sformatf("%s word%0d", req, k), rd_word, m_win[k]);
      end
   endtask

   // one call; poke re-raises start mid-call (R7); inputs scrambled after accept (R8)
   task automatic run_upd(input logic [31:0] d, input int p, input bit poke, input string req);
      @(negedge clk);
      start = 1'b1; sample_in = d; pos_in = 6'(p);
      for (int k = 1; k <= 7; k++) begin
         @(negedge clk);
         start     = poke && (k >= 2) && (k <= 6);
         sample_in = ~d ^ 32'(k);
         pos_in    = 6'(p) ^ 6'h2a;
         chk($sformatf("R6 done at step %0d", k), {31'b0, done}, {31'b0, (k == 7)});
      end
      start = 1'b0;
      model_upd(d, p);
      check_window(req);
   endtask

   initial begin
      #(4 * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog R6 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int k = 0; k < 9; k++) m_win[k] = '0;
      for (int k = 0; k < LEN; k++) begin m_old[k] = '0; m_new[k] = '0; end
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk("R1 done after reset", {31'b0, done}, 32'd0);
      check_window("R1 reset");

      // three full rows: R2 shift, R3/R5 rotation reaching word 2, R4 sample
      for (int row = 0; row < 3; row++)
         for (int col = 0; col < LEN; col++)
            run_upd(32'h0100_0000 * (row + 1) + 32'h11 * col + 32'h5, col,
                    (col % 5) == 2, "R2/R3/R4/R5/R8 row");

      // R9: out-of-range positions leave the buffers alone
      run_upd(32'hdead_0020, 20, 1'b0, "R9 pos20");
      run_upd(32'hdead_003f, 63, 1'b1, "R9 pos63");
      for (int col = 0; col < LEN; col++)
         run_upd(32'h0a00_0000 + 32'h3 * col, col, 1'b0, "R9 R5 buffers untouched");

      // R10: selects past the last word
      for (int s = 9; s < 16; s++) begin
         @(negedge clk);
         rd_sel = 4'(s);
         #0.5;
         chk($sformatf("R10 sel %0d", s), rd_word, 32'h0);
      end

      // R7: start held high gives back-to-back calls eight cycles apart
      @(negedge clk);
      start = 1'b1; sample_in = 32'h7777_0003; pos_in = 6'd3;
      for (int k = 1; k <= 16; k++) begin
         @(negedge clk);
         if (k == 15) start = 1'b0;
         chk($sformatf("R7 held start done at %0d", k), {31'b0, done},
             {31'b0, (k == 7 || k == 15)});
      end
      model_upd(32'h7777_0003, 3);
      model_upd(32'h7777_0003, 3);
      check_window("R7 back-to-back");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule